// File: doc/BRIEF.md
# Slot Timing and Radio Strobe Sequencer

This block builds the slot timebase of a frequency-hopping baseband from a one-microsecond symbol tick. A slot is 625 ticks long. Within each slot the block times three radio strobes: synthesizer enable, transmit enable and receive enable. A receive burst ends with an interrupt to the link-control processor. The processor then has a short, fixed window in which to write the configuration for the next slot through a small register port.

The configuration is a mode (transmit, receive or idle), a 7-bit channel index and a burst length in ticks. It is held in a shadow register. At a fixed programming deadline the block moves it into a pending stage. The deadline lies 180 ticks of synthesizer settling plus a 10-tick transmit margin ahead of the next boundary, at phase 435. If nothing was written since the previous deadline, the block raises a sticky late flag and the next slot runs idle. Three ticks before synthesizer enable, the channel word is shifted out serially and closed with a load pulse. At the boundary the pending stage becomes the active slot configuration.

Top module: `slot_seq`

## Requirements
- R1: The phase register counts ticks 0..624 and wraps to 0. The 28-bit native clock steps by one when the phase enters 312 and when it wraps. Both are readable: phase at address 2, native clock at address 3.
- R2: A write to address 0 stores a configuration with mode in bits [1:0], channel in [8:2] and length in [18:9]. Mode 1 is transmit, mode 2 is receive, and modes 0 and 3 are idle. A write made while the phase is at most 434 takes effect in the next slot.
- R3: At the deadline (phase becomes 435), if no configuration was written since the previous deadline, status bit 0 (address 1) sets and the next slot is idle. The bit stays set until a write to address 1 with bit 0 high.
- R4: A write made at or after the deadline does not affect the next slot. It is held and taken at the following deadline.
- R5: Synthesizer enable is high from phase 445 through 624 when the next slot is transmit or receive, and low at all other times.
- R6: When the next slot is live, the 7-bit channel is shifted out MSB first starting when the phase enters 442. One bit is output per clock, qualified by the serial clock, and a one-clock load pulse follows the last bit. All of this ends before synthesizer enable rises. Idle slots produce no shifting.
- R7: Transmit or receive enable rises when the phase enters 0 and falls when the phase reaches the programmed length.
- R8: Transmit enable and receive enable are never high together.
- R9: The interrupt is a one-clock pulse, issued one clock after receive enable falls.
- R10: After reset all strobes, the interrupt and the late flag are low, and the phase and native clock read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse per microsecond symbol |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 19 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 28 | Read data (combinational) |
| syn_en_o | output | 1 | Synthesizer enable |
| syn_clk_o | output | 1 | Serial bit qualifier for channel word |
| syn_data_o | output | 1 | Serial channel bit |
| syn_load_o | output | 1 | Channel word load pulse |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| irq_o | output | 1 | Receive-end interrupt |

## Verification
The hardest case to reach is a write that lands right around the deadline. A write at phase 434 must be accepted. A write at phase 435 must miss the next slot, raise the late flag and then be picked up one slot later. The bench drives every tick itself and tracks the phase from its own tick count, so it can place a write on either side of that edge. It then follows the idle slot and the delayed live slot through the serial word, the synthesizer enable and the burst strobes.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  localparam int CH_W  = 7;
  localparam int LEN_W = 10;
  localparam int AW    = 2;

  typedef logic [1:0] mode_t;
  localparam mode_t MODE_IDLE = 2'd0;
  localparam mode_t MODE_TX   = 2'd1;
  localparam mode_t MODE_RX   = 2'd2;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CH_W-1:0]  chan;
    mode_t            mode;
  } slot_cfg_t;

  localparam int CFG_W = $bits(slot_cfg_t);

  localparam logic [AW-1:0] A_CFG   = 2'd0;
  localparam logic [AW-1:0] A_STAT  = 2'd1;
  localparam logic [AW-1:0] A_PHASE = 2'd2;
  localparam logic [AW-1:0] A_NCLK  = 2'd3;

  function automatic logic mode_live(mode_t m);
    return (m == MODE_TX) || (m == MODE_RX);
  endfunction
endpackage

// File: rtl/slot_timebase.sv
module slot_timebase #(
  parameter int SLOT_TICKS = 625,
  parameter int DEADLINE   = 435,
  parameter int PRE_START  = 442,
  parameter int NCLK_W     = 28,
  parameter int PH_W       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [NCLK_W-1:0] nclk_o,
  output logic              wrap_o,
  output logic              dl_o,
  output logic              pre_o
);
  localparam int HALF = SLOT_TICKS / 2;

  logic [PH_W-1:0]   cnt_q;
  logic [NCLK_W-1:0] nclk_q;
  logic              last_w, half_w;

  assign last_w = cnt_q == PH_W'(SLOT_TICKS - 1);
  assign half_w = cnt_q == PH_W'(HALF - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      nclk_q <= '0;
    end else if (tick_i) begin
      cnt_q <= last_w ? '0 : cnt_q + 1'b1;
      if (last_w || half_w) nclk_q <= nclk_q + 1'b1;
    end
  end

  // events fire on the tick that moves the phase onto the named value
  assign wrap_o  = tick_i && last_w;
  assign dl_o    = tick_i && (cnt_q == PH_W'(DEADLINE - 1));
  assign pre_o   = tick_i && (cnt_q == PH_W'(PRE_START - 1));
  assign phase_o = cnt_q;
  assign nclk_o  = nclk_q;
endmodule

// File: rtl/slot_cfg_regs.sv
module slot_cfg_regs
  import slot_seq_pkg::*;
#(
  parameter int PH_W   = 10,
  parameter int NCLK_W = 28,
  parameter int RD_W   = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o,
  input  logic              dl_i,
  input  logic              wrap_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [NCLK_W-1:0] nclk_i,
  output slot_cfg_t         pend_o,
  output slot_cfg_t         act_o,
  output logic              late_o
);
  localparam slot_cfg_t IDLE_CFG = '{len: '0, chan: '0, mode: MODE_IDLE};

  slot_cfg_t shadow_q, pend_q, act_q;
  logic      valid_q, late_q;
  logic      cfg_we, late_clr;

  assign cfg_we   = wr_en_i && (wr_addr_i == A_CFG);
  assign late_clr = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= IDLE_CFG;
      pend_q   <= IDLE_CFG;
      act_q    <= IDLE_CFG;
      valid_q  <= 1'b0;
      late_q   <= 1'b0;
    end else begin
      if (cfg_we) shadow_q <= slot_cfg_t'(wr_data_i);
      // a write in the deadline cycle counts toward the following deadline
      if (cfg_we)    valid_q <= 1'b1;
      else if (dl_i) valid_q <= 1'b0;
      if (dl_i) pend_q <= valid_q ? shadow_q : IDLE_CFG;
      if (wrap_i) act_q <= pend_q;
      if (dl_i && !valid_q) late_q <= 1'b1;
      else if (late_clr)    late_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CFG:   rd_data_o = RD_W'(shadow_q);
      A_STAT:  rd_data_o = RD_W'(late_q);
      A_PHASE: rd_data_o = RD_W'(phase_i);
      default: rd_data_o = RD_W'(nclk_i);
    endcase
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign late_o = late_q;
endmodule

// File: rtl/synth_serializer.sv
module synth_serializer #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         sclk_o,
  output logic         sdata_o,
  output logic         sload_o
);
  localparam int BC_W = $clog2(W + 1);

  logic [W-1:0]    sh_q;
  logic [BC_W-1:0] bc_q;
  logic            busy_q, load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bc_q   <= '0;
      busy_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (start_i) begin
        sh_q   <= word_i;
        bc_q   <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q <= sh_q << 1;
        if (bc_q == BC_W'(W - 1)) begin
          busy_q <= 1'b0;
          load_q <= 1'b1;
        end else begin
          bc_q <= bc_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o  = busy_q;
  assign sdata_o = sh_q[W-1];
  assign sload_o = load_q;
endmodule

// File: rtl/slot_strobes.sv
module slot_strobes
  import slot_seq_pkg::*;
#(
  parameter int PH_W      = 10,
  parameter int SYN_START = 445
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  mode_t            act_mode_i,
  input  logic [LEN_W-1:0] act_len_i,
  input  mode_t            pend_mode_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             syn_en_o,
  output logic             irq_o
);
  logic in_burst;
  logic rx_q, irq_q;

  assign in_burst = 32'(phase_i) < 32'(act_len_i);
  assign tx_en_o  = (act_mode_i == MODE_TX) && in_burst;
  assign rx_en_o  = (act_mode_i == MODE_RX) && in_burst;
  assign syn_en_o = mode_live(pend_mode_i) && (32'(phase_i) >= 32'(SYN_START));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rx_q  <= rx_en_o;
      irq_q <= rx_q && !rx_en_o;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/slot_seq.sv
module slot_seq
  import slot_seq_pkg::*;
#(
  parameter int SLOT_TICKS = 625,
  parameter int SYN_LEAD   = 180,
  parameter int PRE_LEAD   = 3,
  parameter int TX_MARGIN  = 10,
  parameter int NCLK_W     = 28,
  localparam int PH_W      = $clog2(SLOT_TICKS),
  localparam int RD_A      = (NCLK_W > PH_W) ? NCLK_W : PH_W,
  localparam int RD_W      = (RD_A > CFG_W) ? RD_A : CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic             syn_en_o,
  output logic             syn_clk_o,
  output logic             syn_data_o,
  output logic             syn_load_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             irq_o
);
  localparam int SYN_START = SLOT_TICKS - SYN_LEAD;
  localparam int DEADLINE  = SYN_START - TX_MARGIN;
  localparam int PRE_START = SYN_START - PRE_LEAD;

  logic [PH_W-1:0]   phase_w;
  logic [NCLK_W-1:0] nclk_w;
  logic              wrap_w, dl_w, pre_w, late_w;
  slot_cfg_t         pend_w, act_w;

  slot_timebase #(
    .SLOT_TICKS(SLOT_TICKS), .DEADLINE(DEADLINE), .PRE_START(PRE_START),
    .NCLK_W(NCLK_W), .PH_W(PH_W)
  ) u_tb (
    .clk_i, .rst_ni, .tick_i,
    .phase_o(phase_w), .nclk_o(nclk_w),
    .wrap_o(wrap_w), .dl_o(dl_w), .pre_o(pre_w)
  );

  slot_cfg_regs #(.PH_W(PH_W), .NCLK_W(NCLK_W), .RD_W(RD_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .dl_i(dl_w), .wrap_i(wrap_w), .phase_i(phase_w), .nclk_i(nclk_w),
    .pend_o(pend_w), .act_o(act_w), .late_o(late_w)
  );

  synth_serializer #(.W(CH_W)) u_ser (
    .clk_i, .rst_ni,
    .start_i(pre_w && mode_live(pend_w.mode)), .word_i(pend_w.chan),
    .sclk_o(syn_clk_o), .sdata_o(syn_data_o), .sload_o(syn_load_o)
  );

  slot_strobes #(.PH_W(PH_W), .SYN_START(SYN_START)) u_str (
    .clk_i, .rst_ni, .phase_i(phase_w),
    .act_mode_i(act_w.mode), .act_len_i(act_w.len), .pend_mode_i(pend_w.mode),
    .tx_en_o, .rx_en_o, .syn_en_o, .irq_o
  );
endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk
  import slot_seq_pkg::*;
#(
  parameter int PH_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_en_o,
  input logic            rx_en_o,
  input logic            syn_en_o,
  input logic            syn_clk_o,
  input logic            irq_o,
  input logic            late_w,
  input logic [PH_W-1:0] phase_w,
  input logic            wr_en_i,
  input logic [AW-1:0]   wr_addr_i,
  input logic [CFG_W-1:0] wr_data_i
);
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_o && rx_en_o));

  assert_irq_after_rx_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(rx_en_o, 2) && !$past(rx_en_o)));

  assert_serial_before_syn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_clk_o |-> !syn_en_o);

  assert_late_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_w && !(wr_en_i && wr_addr_i == A_STAT && wr_data_i[0])) |=> late_w);

  assert_tx_rise_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (phase_w == '0));

  assert_rx_rise_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> (phase_w == '0));
endmodule

bind slot_seq slot_seq_chk #(.PH_W(PH_W)) u_chk (
  .clk_i, .rst_ni, .tx_en_o, .rx_en_o, .syn_en_o, .syn_clk_o, .irq_o,
  .late_w, .phase_w, .wr_en_i, .wr_addr_i, .wr_data_i
);

// File: tb/tb_slot_seq.sv
module tb_slot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 625;
  localparam int WD_CYCLES = 190000;
  localparam int NV = 6;
  // {write_made, mode[1:0], chan[6:0], len[9:0]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd1, 7'h55, 10'd100},
    {1'b1, 2'd2, 7'h2A, 10'd384},
    {1'b1, 2'd0, 7'h11, 10'd50},
    {1'b0, 2'd1, 7'h66, 10'd40},
    {1'b1, 2'd1, 7'h7F, 10'd624},
    {1'b1, 2'd2, 7'h01, 10'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [18:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [27:0] rd_data_o;
  logic syn_en_o, syn_clk_o, syn_data_o, syn_load_o, tx_en_o, rx_en_o, irq_o;

  int total = 0, bad = 0, tk = 0;
  int load_cnt = 0, irq_cnt = 0;
  logic [6:0] cap = '0, last_word = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  slot_seq dut (.*);

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (syn_clk_o) cap = {cap[5:0], syn_data_o};
      if (syn_load_o) begin load_cnt++; last_word = cap; end
      if (irq_o) irq_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (tick %0d)", req, act, exp, tk);
    end
  endtask

  task automatic step();
    @(negedge clk_i); @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    tk++;
  endtask

  task automatic goto_phase(input int p);
    while (tk % SLOT != p) step();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [18:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output int v);
    rd_addr_i = a;
    #1;
    v = int'(rd_data_o);
  endtask

  function automatic int exp_nclk();
    return 2 * (tk / SLOT) + (((tk % SLOT) >= 312) ? 1 : 0);
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, lc, ic;
    logic ok;
    logic [1:0] md;
    logic [6:0] ch;
    logic [9:0] ln;
    int live, txe, rxe;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 tx", tx_en_o, 0);
    chk("R10 rx", rx_en_o, 0);
    chk("R10 syn", syn_en_o, 0);
    chk("R10 irq", irq_o, 0);
    rreg(2'd1, v); chk("R10 late", v, 0);
    rreg(2'd2, v); chk("R10 phase", v, 0);
    rreg(2'd3, v); chk("R10 nclk", v, 0);

    // R1 phase and native clock
    goto_phase(311); rreg(2'd3, v); chk("R1 nclk before half", v, exp_nclk());
    goto_phase(312); rreg(2'd3, v); chk("R1 nclk at half", v, 1);
    rreg(2'd2, v); chk("R1 phase", v, 312);
    goto_phase(0); rreg(2'd3, v); chk("R1 nclk at wrap", v, 2);
    rreg(2'd2, v); chk("R1 phase wrap", v, 0);

    // table of vectors, covers R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      {ok, md, ch, ln} = VEC[i];
      goto_phase(10);
      wreg(2'd1, 19'd1);
      lc = load_cnt; ic = irq_cnt;
      if (ok) wreg(2'd0, {ln, ch, md});
      live = (ok && (md == 2'd1 || md == 2'd2)) ? 1 : 0;
      txe  = (ok && md == 2'd1) ? 1 : 0;
      rxe  = (ok && md == 2'd2) ? 1 : 0;
      goto_phase(444);
      chk("R5 syn before start", syn_en_o, 0);
      goto_phase(445);
      chk("R5 syn at start", syn_en_o, live);
      chk("R6 load count", load_cnt - lc, live);
      if (live == 1) chk("R6 channel word", last_word, ch);
      rreg(2'd1, v); chk("R3 late flag", v, ok ? 0 : 1);
      rreg(2'd3, v); chk("R1 nclk", v, exp_nclk());
      goto_phase(624);
      chk("R5 syn end of slot", syn_en_o, live);
      goto_phase(0);
      chk("R7 tx at boundary", tx_en_o, txe);
      chk("R7 rx at boundary", rx_en_o, rxe);
      chk("R8 exclusive", tx_en_o & rx_en_o, 0);
      goto_phase(ln - 1);
      chk("R7 tx last tick", tx_en_o, txe);
      chk("R7 rx last tick", rx_en_o, rxe);
      goto_phase(ln);
      chk("R7 tx off", tx_en_o, 0);
      chk("R7 rx off", rx_en_o, 0);
      repeat (3) @(negedge clk_i);
      chk("R9 irq count", irq_cnt - ic, rxe);
    end

    // R2 boundary: write one tick before the deadline is accepted
    goto_phase(10); wreg(2'd1, 19'd1);
    goto_phase(434); wreg(2'd0, {10'd20, 7'h33, 2'd1});
    goto_phase(445);
    chk("R2 write at 434 syn", syn_en_o, 1);
    chk("R2 write at 434 word", last_word, 7'h33);
    rreg(2'd1, v); chk("R2 write at 434 late", v, 0);
    goto_phase(0); chk("R2 write at 434 tx", tx_en_o, 1);

    // R4: write at the deadline phase misses one slot and is carried
    goto_phase(10); wreg(2'd1, 19'd1);
    goto_phase(435); wreg(2'd0, {10'd30, 7'h44, 2'd2});
    goto_phase(445);
    rreg(2'd1, v); chk("R4 late set", v, 1);
    chk("R4 syn idle", syn_en_o, 0);
    goto_phase(0); chk("R4 idle slot rx", rx_en_o, 0);
    wreg(2'd1, 19'd1);
    lc = load_cnt; ic = irq_cnt;
    goto_phase(445);
    chk("R4 carried syn", syn_en_o, 1);
    chk("R4 carried word", last_word, 7'h44);
    chk("R4 carried load", load_cnt - lc, 1);
    rreg(2'd1, v); chk("R4 no new late", v, 0);
    goto_phase(0); chk("R4 carried rx", rx_en_o, 1);
    goto_phase(30); chk("R4 carried rx off", rx_en_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R9 carried irq", irq_cnt - ic, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule